// File: doc/BRIEF.md
# Reloading 16-bit Down-Counter with Pulse Output

This block is a 16-bit down-counter with a reload register, programmed over a narrow 8-bit register bus. When the count sits at zero, the next count enable reloads it from the reload register and raises an interrupt request flag. The flag stays raised until software clears it. In pulse mode, every such wrap also inverts a square-wave output. Count enables come from one of four sources: a fixed fast divide of the clock, a fixed slow divide, a slow sub-clock enable strobe, or synchronized edges on an external count pin.

A run/halt state machine decides whether counting happens and what a count write does. In the halted state (`RUN_HALT`), a 16-bit write lands in both the reload register and the counter. In the running state (`RUN_GO`), it lands only in the reload register. There are two transitions: `GO_START` (a control write with bit 0 = 0 while halted) and `GO_STOP` (a control write with bit 0 = 1 while running). Software moves the 16-bit value a byte at a time. A low-byte write is parked until the matching high-byte write, and a high-byte read freezes the low byte for the read that follows.

Register map (3-bit address): 0 = count low byte, 1 = count high byte, 2 = mode byte (bits [2:0] operating mode, bit 5 polarity, bits [7:6] count source; all 8 bits read back), 3 = control (bit 0 = halt), 4 = status (bit 0 = interrupt request, write 1 to clear). Other addresses read 0.

Top module: `mrt16_timer`

## Requirements
- R1: While running with a supported mode, each count enable lowers the count by one. An enable that arrives with the count at 0x0000 loads the reload value instead.
- R2: Each wrap sets the interrupt flag (status bit 0, output irq_req). The flag stays set until a write to address 4 with bit 0 = 1. A wrap in the same cycle as that write leaves the flag set.
- R3: After reset the block is halted (control bit 0 reads 1), the mode byte is 0x00, irq_req is 0 and pulse_out is 0. Writing control bit 0 = 0 starts counting, and writing 1 halts it with the count held.
- R4: A committed 16-bit write while halted sets both the reload value and the count. While running it sets only the reload value, and the count takes it at the next wrap.
- R5: A write to address 0 is buffered with no visible effect on the count. A write to address 1 commits {high byte, buffered low byte}. A read of address 1 returns count bits [15:8] and captures bits [7:0], and a later read of address 0 returns that captured byte.
- R6: Mode bits [7:6] pick the count enable: 00 gives one enable every 2 clocks, 01 gives one every 16 clocks, 10 gives one per clock with sub_tick high, and 11 gives edges of cnt_pin.
- R7: cnt_pin passes through two synchronizer flops. With mode bit 5 = 0 rising edges count, and with bit 5 = 1 falling edges count. A pin change first sampled at clock edge k moves the count at edge k+2.
- R8: In pulse mode (bits [2:0] = 001), pulse_out inverts on each wrap. Any mode write sets the starting level to the inverse of bit 5, so bit 5 = 0 starts high and bit 5 = 1 starts low. pulse_out is 0 in any other mode.
- R9: Mode codes other than 000 and 001 freeze the count even while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| sub_tick | input | 1 | Slow sub-clock enable strobe |
| cnt_pin | input | 1 | External count pin, asynchronous |
| pulse_out | output | 1 | Toggling output in pulse mode |
| irq_req | output | 1 | Interrupt request flag |

## Verification
The bench builds the block with the default dividers of 2 and 16 and a two-flop synchronizer. With these values, several wraps of a small reload value happen within a few hundred cycles, and the prescaler phase makes the count land in a narrow, predictable window. The sub-clock source is driven one strobe at a time. This gives exact counts and lets a wrap be placed in the same cycle as a flag-clear write, or right after a mode write. The external pin is toggled with enough hold time to expose the two-edge latency and the polarity choice.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

    typedef enum logic [1:0] {
        SRC_FAST = 2'b00,
        SRC_SLOW = 2'b01,
        SRC_SUB  = 2'b10,
        SRC_PIN  = 2'b11
    } src_e;

    typedef enum logic {
        RUN_HALT = 1'b0,
        RUN_GO   = 1'b1
    } run_e;

    localparam logic [2:0] MODE_COUNT = 3'b000;
    localparam logic [2:0] MODE_PULSE = 3'b001;

    localparam logic [2:0] ADR_LO   = 3'd0;
    localparam logic [2:0] ADR_HI   = 3'd1;
    localparam logic [2:0] ADR_MODE = 3'd2;
    localparam logic [2:0] ADR_CTRL = 3'd3;
    localparam logic [2:0] ADR_STAT = 3'd4;

endpackage

// File: rtl/mrt_tick_gen.sv
module mrt_tick_gen
    import mrt_pkg::*;
#(
    parameter int DIV_FAST    = 2,
    parameter int DIV_SLOW    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src,
    input  logic       edge_sel,
    input  logic       sub_tick,
    input  logic       cnt_pin,
    output logic       tick
);

    localparam int FW = (DIV_FAST > 1) ? $clog2(DIV_FAST) : 1;
    localparam int SW = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;
    localparam logic [FW-1:0] FAST_LAST = FW'(DIV_FAST - 1);
    localparam logic [SW-1:0] SLOW_LAST = SW'(DIV_SLOW - 1);

    logic [FW-1:0]        div_fast;
    logic [SW-1:0]        div_slow;
    logic [SYNC_STAGES:0] pin_sh;
    logic                 pin_now;
    logic                 pin_old;
    logic                 pin_edge;

    // free-running dividers, each wraps at its own divisor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_fast <= '0;
            div_slow <= '0;
        end else begin
            div_fast <= (div_fast == FAST_LAST) ? '0 : div_fast + 1'b1;
            div_slow <= (div_slow == SLOW_LAST) ? '0 : div_slow + 1'b1;
        end
    end

    // synchronizer chain plus one history flop for edge detection
    generate
        for (genvar g = 0; g <= SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) pin_sh[0] <= 1'b0;
                    else        pin_sh[0] <= cnt_pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) pin_sh[g] <= 1'b0;
                    else        pin_sh[g] <= pin_sh[g-1];
                end
            end
        end
    endgenerate

    assign pin_now  = pin_sh[SYNC_STAGES-1];
    assign pin_old  = pin_sh[SYNC_STAGES];
    assign pin_edge = edge_sel ? (pin_old & ~pin_now) : (pin_now & ~pin_old);

    always_comb begin
        tick = 1'b0;
        unique case (src_e'(src))
            SRC_FAST: tick = (div_fast == FAST_LAST);
            SRC_SLOW: tick = (div_slow == SLOW_LAST);
            SRC_SUB:  tick = sub_tick;
            SRC_PIN:  tick = pin_edge;
        endcase
    end

endmodule

// File: rtl/mrt_regs.sv
module mrt_regs
    import mrt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic              uf,
    input  run_e              run_st,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic [BYTE_W-1:0] mode_reg,
    output logic              mode_wr,
    output logic              commit,
    output logic [CNT_W-1:0]  commit_val,
    output logic              stop_wr,
    output logic              stop_val,
    output logic              irq_req
);

    localparam int HI_W = CNT_W - BYTE_W;

    logic [BYTE_W-1:0] lo_buf;
    logic [BYTE_W-1:0] lo_hold;
    logic              wr_lo;
    logic              wr_hi;
    logic              wr_clr;
    logic              rd_hi;

    assign wr_lo   = bus_wr && (bus_addr == ADR_LO);
    assign wr_hi   = bus_wr && (bus_addr == ADR_HI);
    assign mode_wr = bus_wr && (bus_addr == ADR_MODE);
    assign stop_wr = bus_wr && (bus_addr == ADR_CTRL);
    assign wr_clr  = bus_wr && (bus_addr == ADR_STAT) && bus_wdata[0];
    assign rd_hi   = bus_rd && (bus_addr == ADR_HI);

    assign stop_val   = bus_wdata[0];
    assign commit     = wr_hi;
    assign commit_val = {bus_wdata[HI_W-1:0], lo_buf};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_buf   <= '0;
            lo_hold  <= '0;
            mode_reg <= '0;
            irq_req  <= 1'b0;
        end else begin
            if (wr_lo)   lo_buf   <= bus_wdata;
            if (rd_hi)   lo_hold  <= cnt_q[BYTE_W-1:0];
            if (mode_wr) mode_reg <= bus_wdata;
            // a wrap outranks a clear arriving in the same cycle
            if (uf)          irq_req <= 1'b1;
            else if (wr_clr) irq_req <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_LO:   bus_rdata = lo_hold;
            ADR_HI:   bus_rdata = BYTE_W'(cnt_q[CNT_W-1:BYTE_W]);
            ADR_MODE: bus_rdata = mode_reg;
            ADR_CTRL: bus_rdata = {{(BYTE_W-1){1'b0}}, (run_st == RUN_HALT)};
            ADR_STAT: bus_rdata = {{(BYTE_W-1){1'b0}}, irq_req};
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mrt_core.sv
module mrt_core
    import mrt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [2:0]       mode,
    input  logic             mode_wr,
    input  logic             pol_new,
    input  logic             commit,
    input  logic [CNT_W-1:0] commit_val,
    input  logic             stop_wr,
    input  logic             stop_val,
    output run_e             run_st,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] latch_q,
    output logic             uf,
    output logic             pulse_out
);

    run_e st_nx;
    logic mode_ok;
    logic step;
    logic lvl_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) run_st <= RUN_HALT;
        else        run_st <= st_nx;
    end

    // transitions GO_START and GO_STOP
    always_comb begin
        st_nx = run_st;
        unique case (run_st)
            RUN_HALT: if (stop_wr && !stop_val) st_nx = RUN_GO;
            RUN_GO:   if (stop_wr &&  stop_val) st_nx = RUN_HALT;
        endcase
    end

    assign mode_ok = (mode == MODE_COUNT) || (mode == MODE_PULSE);
    assign step    = (run_st == RUN_GO) && tick && mode_ok;
    assign uf      = step && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            latch_q <= '0;
        end else begin
            if (commit) latch_q <= commit_val;
            unique case (run_st)
                RUN_HALT: if (commit) cnt_q <= commit_val;
                RUN_GO:   if (step)   cnt_q <= (cnt_q == '0) ? latch_q : cnt_q - 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                        lvl_q <= 1'b1;
        else if (mode_wr)                  lvl_q <= ~pol_new;
        else if (uf && mode == MODE_PULSE) lvl_q <= ~lvl_q;
    end

    // output process
    always_comb begin
        pulse_out = (mode == MODE_PULSE) ? lvl_q : 1'b0;
    end

endmodule

// File: rtl/mrt16_timer.sv
module mrt16_timer
    import mrt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int BYTE_W      = 8,
    parameter int DIV_FAST    = 2,
    parameter int DIV_SLOW    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        sub_tick,
    input  logic        cnt_pin,
    output logic        pulse_out,
    output logic        irq_req
);

    run_e              run_st;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  latch_q;
    logic [BYTE_W-1:0] mode_reg;
    logic [2:0]        mode_q;
    logic              tick_q;
    logic              uf;
    logic              mode_wr;
    logic              commit;
    logic [CNT_W-1:0]  commit_val;
    logic              stop_wr;
    logic              stop_val;

    assign mode_q = mode_reg[2:0];

    mrt_tick_gen #(
        .DIV_FAST   (DIV_FAST),
        .DIV_SLOW   (DIV_SLOW),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (mode_reg[7:6]),
        .edge_sel(mode_reg[5]),
        .sub_tick(sub_tick),
        .cnt_pin (cnt_pin),
        .tick    (tick_q)
    );

    mrt_regs #(
        .CNT_W (CNT_W),
        .BYTE_W(BYTE_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_q     (cnt_q),
        .uf        (uf),
        .run_st    (run_st),
        .bus_rdata (bus_rdata),
        .mode_reg  (mode_reg),
        .mode_wr   (mode_wr),
        .commit    (commit),
        .commit_val(commit_val),
        .stop_wr   (stop_wr),
        .stop_val  (stop_val),
        .irq_req   (irq_req)
    );

    mrt_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_q),
        .mode      (mode_q),
        .mode_wr   (mode_wr),
        .pol_new   (bus_wdata[5]),
        .commit    (commit),
        .commit_val(commit_val),
        .stop_wr   (stop_wr),
        .stop_val  (stop_val),
        .run_st    (run_st),
        .cnt_q     (cnt_q),
        .latch_q   (latch_q),
        .uf        (uf),
        .pulse_out (pulse_out)
    );

endmodule

// File: rtl/mrt16_timer_chk.sv
module mrt16_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_go,
    input logic             tick_q,
    input logic [2:0]       mode_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] latch_q,
    input logic             bus_wr,
    input logic [2:0]       bus_addr,
    input logic             irq_req,
    input logic             pulse_out
);

    logic sup;
    logic wrap;
    logic hi_wr;
    logic mode_write;

    assign sup        = (mode_q == 3'b000) || (mode_q == 3'b001);
    assign wrap       = run_go && tick_q && sup && (cnt_q == '0);
    assign hi_wr      = bus_wr && (bus_addr == 3'd1);
    assign mode_write = bus_wr && (bus_addr == 3'd2);

    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == $past(latch_q))); // R1

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (run_go && tick_q && sup && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R1

    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> irq_req); // R2

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_go && !hi_wr) |=> $stable(cnt_q)); // R3

    AST_PULSE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && mode_q == 3'b001 && !mode_write) |=> (pulse_out != $past(pulse_out))); // R8

    AST_BAD_MODE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sup && !hi_wr) |=> $stable(cnt_q)); // R9

    AST_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != 3'b001) |-> !pulse_out); // R8

endmodule

bind mrt16_timer mrt16_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_go   (run_st == mrt_pkg::RUN_GO),
    .tick_q   (tick_q),
    .mode_q   (mode_q),
    .cnt_q    (cnt_q),
    .latch_q  (latch_q),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .irq_req  (irq_req),
    .pulse_out(pulse_out)
);

// File: tb/sim_mrt16_timer.sv
`timescale 1ns/1ps
module sim_mrt16_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       sub_tick = 1'b0;
    logic       cnt_pin = 1'b0;
    logic       pulse_out;
    logic       irq_req;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mrt16_timer #(
        .CNT_W(16), .BYTE_W(8), .DIV_FAST(2), .DIV_SLOW(16), .SYNC_STAGES(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sub_tick(sub_tick), .cnt_pin(cnt_pin), .pulse_out(pulse_out),
        .irq_req(irq_req)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_rng(input string tag, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h..%0h", tag, act, lo, hi);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int       m_cyc;
    int       m_cnt, m_latch, m_lobuf, m_hold, m_mode;
    bit       m_run, m_irq, m_lvl;
    bit       m_pins[$];

    function automatic int exp_rdata(input logic [2:0] a);
        case (a)
            3'd0: return m_hold;
            3'd1: return (m_cnt >> 8) & 255;
            3'd2: return m_mode;
            3'd3: return m_run ? 0 : 1;
            3'd4: return m_irq ? 1 : 0;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cyc = 0; m_cnt = 0; m_latch = 0; m_lobuf = 0; m_hold = 0;
            m_mode = 0; m_run = 0; m_irq = 0; m_lvl = 1;
            m_pins = '{0, 0, 0};
        end else begin
            bit en, ok, wrap;
            int src, n_cnt;
            src = (m_mode >> 6) & 3;
            case (src)
                0: en = (m_cyc % 2) == 1;
                1: en = (m_cyc % 16) == 15;
                2: en = sub_tick;
                default: en = ((m_mode >> 5) & 1) ? (m_pins[2] && !m_pins[1])
                                                  : (m_pins[1] && !m_pins[2]);
            endcase
            ok    = ((m_mode & 7) == 0) || ((m_mode & 7) == 1);
            wrap  = m_run && en && ok && (m_cnt == 0);
            n_cnt = m_cnt;
            if (m_run && en && ok) n_cnt = (m_cnt == 0) ? m_latch : m_cnt - 1;
            if (bus_rd && bus_addr == 3'd1) m_hold = m_cnt & 255;
            if (bus_wr && bus_addr == 3'd0) m_lobuf = bus_wdata;
            if (bus_wr && bus_addr == 3'd1) begin
                if (!m_run) n_cnt = bus_wdata * 256 + m_lobuf;
                m_latch = bus_wdata * 256 + m_lobuf;
            end
            if (bus_wr && bus_addr == 3'd2) m_lvl = !bus_wdata[5];
            else if (wrap && (m_mode & 7) == 1) m_lvl = !m_lvl;
            if (wrap) m_irq = 1;
            else if (bus_wr && bus_addr == 3'd4 && bus_wdata[0]) m_irq = 0;
            if (bus_wr && bus_addr == 3'd2) m_mode = bus_wdata;
            if (bus_wr && bus_addr == 3'd3) m_run = !bus_wdata[0];
            m_cnt = n_cnt;
            m_pins.push_front(cnt_pin);
            void'(m_pins.pop_back());
            m_cyc++;
        end
    end

    // per-clock comparison, one time unit after the edge
    always begin
        @(posedge clk);
        #1;
        if (rst_n && !done) begin
            check("R2 model irq_req", irq_req, m_irq);
            check("R8 model pulse_out", pulse_out, ((m_mode & 7) == 1) ? m_lvl : 0);
            check("R5 model bus_rdata", bus_rdata, exp_rdata(bus_addr));
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic write16(input int v);
        wr(3'd0, 8'(v & 255));
        wr(3'd1, 8'((v >> 8) & 255));
    endtask

    task automatic read16(output int v);
        int h, l;
        rd(3'd1, h);
        rd(3'd0, l);
        v = h * 256 + l;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sub_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sub_tick = 1'b1;
            @(negedge clk); sub_tick = 1'b0;
        end
    endtask

    task automatic pin_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            cnt_pin = 1'b1; idle(4);
            cnt_pin = 1'b0; idle(4);
        end
        idle(4);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int v, v2, got;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R3 reset state
        rd(3'd3, v); check("R3 halted after reset", v, 1);
        rd(3'd4, v); check("R3 irq clear after reset", v, 0);
        rd(3'd2, v); check("R3 mode byte after reset", v, 0);
        check("R3 pulse_out after reset", pulse_out, 0);

        // R4/R5 halted write lands in counter
        write16(16'h12AB);
        read16(v); check("R4 halted write to counter", v, 16'h12AB);
        wr(3'd0, 8'h11);
        read16(v); check("R5 low write alone has no effect", v, 16'h12AB);
        rd(3'd1, v); check("R5 high read", v, 8'h12);
        write16(16'h5678);
        rd(3'd0, v); check("R5 low read returns captured byte", v, 8'hAB);

        // R1/R2 wraps with the fast divider
        wr(3'd2, 8'h00);
        write16(3);
        wr(3'd3, 8'h00);
        idle(20);
        rd(3'd4, v); check("R1 R2 wrap raises flag", v, 1);
        wr(3'd3, 8'h01);
        read16(v); idle(10); read16(v2);
        check("R3 halted count holds", v2, v);

        // R4 running write only loads the reload register
        write16(16'h0100);
        wr(3'd4, 8'h01);
        rd(3'd4, v); check("R2 flag cleared by write 1", v, 0);
        wr(3'd3, 8'h00);
        write16(5);
        read16(v); check_rng("R4 running write leaves count", v, 16'h00C0, 16'h0100);
        got = 0;
        for (int i = 0; i < 1000 && got == 0; i++) begin
            rd(3'd4, got);
        end
        check("R1 wrap seen", got, 1);
        read16(v); check_rng("R4 reload value taken at wrap", v, 0, 5);
        wr(3'd3, 8'h01);

        // R6 sources
        write16(100);
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h00); idle(40); wr(3'd3, 8'h01);
        read16(v); check_rng("R6 fast divider rate", v, 77, 81);
        write16(100);
        wr(3'd2, 8'h40);
        wr(3'd3, 8'h00); idle(160); wr(3'd3, 8'h01);
        read16(v); check_rng("R6 slow divider rate", v, 88, 91);
        write16(100);
        wr(3'd2, 8'h80);
        wr(3'd3, 8'h00); sub_pulses(7); wr(3'd3, 8'h01);
        read16(v); check("R6 sub-clock strobes", v, 93);

        // R7 pin edges
        write16(50);
        wr(3'd2, 8'hC0);
        wr(3'd3, 8'h00); pin_pulses(4); wr(3'd3, 8'h01);
        read16(v); check("R7 rising edges counted", v, 46);
        wr(3'd2, 8'hE0);
        wr(3'd3, 8'h00); pin_pulses(3); wr(3'd3, 8'h01);
        read16(v); check("R7 falling edges counted", v, 43);
        wr(3'd3, 8'h00);
        @(negedge clk); cnt_pin = 1'b1;
        @(negedge clk); cnt_pin = 1'b0;
        idle(1);
        read16(v); check("R7 latency before falling edge counts", v, 43);
        idle(3);
        read16(v); check("R7 falling edge counted after sync", v, 42);
        wr(3'd3, 8'h01);

        // R8 pulse output
        wr(3'd2, 8'hA1); check("R8 polarity 1 starts low", pulse_out, 0);
        wr(3'd2, 8'h81); check("R8 polarity 0 starts high", pulse_out, 1);
        write16(0);
        wr(3'd4, 8'h01);
        wr(3'd3, 8'h00);
        sub_pulses(1); check("R8 toggles on wrap", pulse_out, 0);
        sub_pulses(1); check("R8 toggles back", pulse_out, 1);

        // R2 set wins over clear
        wr(3'd4, 8'h01); check("R2 clear", irq_req, 0);
        @(negedge clk);
        sub_tick = 1'b1; bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h01;
        @(negedge clk);
        sub_tick = 1'b0; bus_wr = 1'b0;
        check("R2 wrap beats clear", irq_req, 1);
        wr(3'd4, 8'h01); check("R2 clear after collision", irq_req, 0);

        // R9 unsupported mode freezes count
        wr(3'd3, 8'h01);
        wr(3'd2, 8'h82);
        write16(20);
        wr(3'd3, 8'h00); sub_pulses(5);
        check("R8 pulse_out low outside pulse mode", pulse_out, 0);
        wr(3'd3, 8'h01);
        read16(v); check("R9 bad mode holds count", v, 20);
        rd(3'd4, v); check("R9 no wrap in bad mode", v, 0);

        idle(4);
        finish_run();
    end

endmodule